// File: doc/BRIEF.md
# Clock Chip Interrupt Flag Controller

This block is the interrupt side of a real-time clock. It watches three kinds of event: an edge from the periodic divider tap, a pulse that marks the end of each once-per-second time update, and the current seconds, minutes and hours bytes. The alarm bytes are compared with the time bytes. Events latch sticky flags in a status register. The flags are gated by the enables in a control register, and the result drives an active-low interrupt line.

Software reads the status register to find out which events occurred. That read also clears every flag. A validity register always reports good RAM and time.

The block does not keep time, divide the oscillator or make a square wave. It only stores the square-wave enable bit.

Register addresses on the 4-bit bus:
- 0: alarm seconds
- 1: alarm minutes
- 2: alarm hours
- 3: control
- 4: status
- 5: validity

Unmapped addresses read 0.

Control register bits:
- bit 7: SET (update inhibit)
- bit 6: periodic interrupt enable
- bit 5: alarm interrupt enable
- bit 4: update interrupt enable
- bit 3: square-wave enable
- bits 2:0: plain storage

Status register bits:
- bit 7: summary flag
- bit 6: periodic flag
- bit 5: alarm flag
- bit 4: update flag
- bits 3:0: always 0

Read data is registered and appears one cycle after `rd_en`.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: A synchronous reset clears the three flags and control bits 6:3 and drives `irq_n` high. Control bits 7 and 2:0 keep their value through reset.
- R2: A status read returns bit 4 = update flag, bit 5 = alarm flag, bit 6 = periodic flag and bit 7 = summary flag. Bits 3:0 always read 0.
- R3: The summary bit is 1, and `irq_n` is 0, whenever some flag is set together with its enable. Periodic pairs with control bit 6, alarm with bit 5, and update with bit 4.
- R4: A `periodic_tick` pulse sets the periodic flag even when the periodic enable is 0. In that case `irq_n` stays high.
- R5: An `update_done` pulse sets the update flag.
- R6: On an `update_done` pulse, the alarm flag is set when seconds, minutes and hours each equal their alarm byte.
- R7: An alarm byte with bits 7:6 = 11 matches any time value.
- R8: A status read clears all three flags, so a second read returns 0x00 and `irq_n` returns high.
- R9: A flag whose event arrives in the same cycle as a status read is not returned by that read, and it stays set for the next read.
- R10: A control write with bit 7 = 1 forces the update interrupt enable to 0, whatever bit 4 of the written data is.
- R11: The validity register reads 0x80. Writes to the validity and status registers have no effect.
- R12: While `irq_n` is low, a new event for a flag that is already set keeps `irq_n` low without a high pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| periodic_tick | input | 1 | One-cycle pulse from the selected divider tap |
| update_done | input | 1 | One-cycle pulse at the end of each time update |
| now_sec | input | 8 | Current seconds byte |
| now_min | input | 8 | Current minutes byte |
| now_hr | input | 8 | Current hours byte |
| irq_n | output | 1 | Registered active-low interrupt |

## Verification
The hardest case to reach from the ports is an event landing in the same clock as the status read that clears it. The stimulus raises `periodic_tick` and a status read on one shared falling edge. It then expects the first read to return 0x00 and the second to return 0x40.

A second hard case is a repeat event on a flag that is already pending. The stimulus pulses `update_done` while the update flag is set, and samples `irq_n` on every falling edge to show it never goes high. The don't-care alarm code is exercised with time bytes that differ from every alarm byte except the exact seconds match.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 4;
  localparam int TIME_BYTES = 3;

  localparam logic [ADDR_W-1:0] A_ALM_SEC = 4'd0;
  localparam logic [ADDR_W-1:0] A_CTRL    = 4'd3;
  localparam logic [ADDR_W-1:0] A_STAT    = 4'd4;
  localparam logic [ADDR_W-1:0] A_VALID   = 4'd5;

  localparam int CB_SET = 7;
  localparam int CB_UEN = 4;
  localparam int CB_EN_LO = 4;
  localparam int CB_EN_HI = 6;
  localparam int CB_RST_LO = 3;

  localparam logic [BYTE_W-1:0] VALID_WORD = 8'h80;

  // Packed order matches status bits 6:4.
  typedef struct packed {
    logic pf;
    logic af;
    logic uf;
  } flags_t;
endpackage

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
  parameter int NBYTES = 3,
  parameter int W = 8
) (
  input  logic [NBYTES*W-1:0] alarm_vec,
  input  logic [NBYTES*W-1:0] now_vec,
  output logic                hit
);
  logic [NBYTES-1:0] m;

  generate
    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
      logic [W-1:0] a;
      logic [W-1:0] n;
      assign a = alarm_vec[g*W +: W];
      assign n = now_vec[g*W +: W];
      // A byte with its top two bits set is a wildcard.
      assign m[g] = (a[W-1:W-2] == 2'b11) || (a == n);
    end
  endgenerate

  assign hit = &m;
endmodule

// File: rtl/rtc_ctrl_reg.sv
module rtc_ctrl_reg #(
  parameter int W = 8,
  parameter int SET_BIT = 7,
  parameter int UEN_BIT = 4,
  parameter int RST_LO = 3,
  parameter int RST_HI = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q,
  output logic [W-1:0] d
);
  logic [W-1:0] q_r = '0;

  always_comb begin
    d = q_r;
    if (wr) begin
      d = wdata;
      if (wdata[SET_BIT]) d[UEN_BIT] = 1'b0;
    end
    if (rst) d[RST_HI:RST_LO] = '0;
  end

  always_ff @(posedge clk) q_r <= d;

  assign q = q_r;
endmodule

// File: rtl/rtc_flag_bank.sv
module rtc_flag_bank
  import rtc_irq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  flags_t set_ev,
  input  logic   clr,
  input  flags_t en_d,
  output flags_t flag_q,
  output logic   irq_n
);
  flags_t flag_d;
  flags_t flag_r = '0;
  logic   irq_r = 1'b1;

  // The clear acts on the old value, and a set in the same cycle survives.
  assign flag_d = clr ? set_ev : (flag_r | set_ev);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_r <= '0;
      irq_r  <= 1'b1;
    end else begin
      flag_r <= flag_d;
      irq_r  <= ~|(flag_d & en_d);
    end
  end

  assign flag_q = flag_r;
  assign irq_n = irq_r;
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic              periodic_tick,
  input  logic              update_done,
  input  logic [BYTE_W-1:0] now_sec,
  input  logic [BYTE_W-1:0] now_min,
  input  logic [BYTE_W-1:0] now_hr,
  output logic              irq_n
);
  localparam int VEC_W = TIME_BYTES * BYTE_W;

  logic [VEC_W-1:0]  alarm_vec;
  logic [VEC_W-1:0]  now_vec;
  logic [BYTE_W-1:0] ctrl_q;
  logic [BYTE_W-1:0] ctrl_d;
  logic              alarm_hit;
  logic              rd_stat;
  flags_t            set_ev;
  flags_t            en_d;
  flags_t            en_q;
  flags_t            flag_q;
  logic [BYTE_W-1:0] rd_mux;
  logic [BYTE_W-1:0] rdata_r = '0;

  generate
    for (genvar i = 0; i < TIME_BYTES; i++) begin : g_alm
      logic [BYTE_W-1:0] alm_r = '0;
      always_ff @(posedge clk) begin
        if (rst) alm_r <= '0;
        else if (wr_en && addr == A_ALM_SEC + ADDR_W'(i)) alm_r <= wdata;
      end
      assign alarm_vec[i*BYTE_W +: BYTE_W] = alm_r;
    end
  endgenerate

  assign now_vec = {now_hr, now_min, now_sec};

  rtc_alarm_cmp #(.NBYTES(TIME_BYTES), .W(BYTE_W)) u_cmp (
    .alarm_vec(alarm_vec), .now_vec(now_vec), .hit(alarm_hit)
  );

  rtc_ctrl_reg #(
    .W(BYTE_W), .SET_BIT(CB_SET), .UEN_BIT(CB_UEN),
    .RST_LO(CB_RST_LO), .RST_HI(CB_EN_HI)
  ) u_ctrl (
    .clk(clk), .rst(rst), .wr(wr_en && addr == A_CTRL),
    .wdata(wdata), .q(ctrl_q), .d(ctrl_d)
  );

  assign en_d = flags_t'(ctrl_d[CB_EN_HI:CB_EN_LO]);
  assign en_q = flags_t'(ctrl_q[CB_EN_HI:CB_EN_LO]);

  assign set_ev.pf = periodic_tick;
  assign set_ev.uf = update_done;
  assign set_ev.af = update_done && alarm_hit;
  assign rd_stat   = rd_en && addr == A_STAT;

  rtc_flag_bank u_flags (
    .clk(clk), .rst(rst), .set_ev(set_ev), .clr(rd_stat),
    .en_d(en_d), .flag_q(flag_q), .irq_n(irq_n)
  );

  always_comb begin
    rd_mux = '0;
    if (addr < ADDR_W'(TIME_BYTES))
      rd_mux = alarm_vec[addr[1:0]*BYTE_W +: BYTE_W];
    else if (addr == A_CTRL)
      rd_mux = ctrl_q;
    else if (addr == A_STAT)
      rd_mux = {|(flag_q & en_q), flag_q, 4'b0000};
    else if (addr == A_VALID)
      rd_mux = VALID_WORD;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_r <= '0;
    else if (rd_en) rdata_r <= rd_mux;
  end

  assign rdata = rdata_r;
endmodule

// File: rtl/rtc_irq_ctrl_chk.sv
module rtc_irq_ctrl_chk
  import rtc_irq_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [BYTE_W-1:0] wdata,
  input logic [BYTE_W-1:0] rdata,
  input logic              periodic_tick,
  input logic              update_done,
  input logic              irq_n,
  input logic [2:0]        flags,
  input logic [BYTE_W-1:0] ctrl
);
  a_r4_pf_sets: assert property (@(posedge clk) disable iff (rst)
    periodic_tick |=> flags[2]);

  a_r5_uf_sets: assert property (@(posedge clk) disable iff (rst)
    update_done |=> flags[0]);

  a_r8_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == A_STAT && !periodic_tick && !update_done) |=> flags == 3'b000);

  a_r10_set_drops_uie: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_CTRL && wdata[CB_SET]) |=> !ctrl[CB_UEN]);

  a_r3_irq_has_cause: assert property (@(posedge clk) disable iff (rst)
    !irq_n |-> |(flags & ctrl[CB_EN_HI:CB_EN_LO]));

  a_r12_no_extra_edge: assert property (@(posedge clk) disable iff (rst)
    (!irq_n && !(rd_en && addr == A_STAT) && !(wr_en && addr == A_CTRL)) |=> !irq_n);

  a_r11_valid_word: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == A_VALID) |=> rdata == VALID_WORD);
endmodule

bind rtc_irq_ctrl rtc_irq_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .periodic_tick(periodic_tick),
  .update_done(update_done), .irq_n(irq_n), .flags(flag_q), .ctrl(ctrl_q)
);

// File: tb/rtc_irq_ctrl_tb.sv
module rtc_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       periodic_tick = 1'b0;
  logic       update_done = 1'b0;
  logic [7:0] now_sec = '0;
  logic [7:0] now_min = '0;
  logic [7:0] now_hr = '0;
  logic       irq_n;
  logic       rd_seen = 1'b0;
  logic       done = 1'b0;

  int checks = 0;
  int failures = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_irq_ctrl u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .periodic_tick(periodic_tick),
    .update_done(update_done), .now_sec(now_sec), .now_min(now_min),
    .now_hr(now_hr), .irq_n(irq_n)
  );

  always @(posedge clk) rd_seen <= rd_en;

  // Monitor: compare each read result against the queued expectation.
  initial forever begin
    @(negedge clk);
    if (rd_seen && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        failures++;
        $display("FAIL %s rdata actual=%02h expected=%02h", t, rdata, e);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); periodic_tick = 1'b1;
    @(negedge clk); periodic_tick = 1'b0;
  endtask

  task automatic upd(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h);
    @(negedge clk);
    now_sec = s; now_min = m; now_hr = h; update_done = 1'b1;
    @(negedge clk); update_done = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq_n !== e) begin
      failures++;
      $display("FAIL %s irq_n actual=%0b expected=%0b", t, irq_n, e);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset clears enables and flags, keeps SET and low bits
    wr(4'd3, 8'h7F);
    tick();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rd(4'd3, 8'h07, "R1 ctrl after reset");
    chk_irq(1'b1, "R1 irq after reset");
    rd(4'd4, 8'h00, "R1 status after reset");

    // R4: periodic flag sets with enable off, no interrupt
    tick();
    chk_irq(1'b1, "R4 no irq with enable off");
    rd(4'd4, 8'h40, "R4 flag set without enable");
    rd(4'd4, 8'h00, "R8 second read empty");

    // R3 / R2: enabled periodic interrupt
    wr(4'd3, 8'h40);
    tick();
    chk_irq(1'b0, "R3 irq low with enable");
    rd(4'd4, 8'hC0, "R2 status layout periodic");
    chk_irq(1'b1, "R8 irq released by read");

    // R5: update flag with its enable
    wr(4'd3, 8'h10);
    upd(8'h01, 8'h00, 8'h00);
    chk_irq(1'b0, "R5 update irq");
    // R12: repeat event while pending keeps irq low
    @(negedge clk); update_done = 1'b1;
    chk_irq(1'b0, "R12 low during repeat event");
    @(negedge clk); update_done = 1'b0;
    chk_irq(1'b0, "R12 low after repeat event");
    rd(4'd4, 8'h90, "R5 update flag read");

    // R10: SET write drops update enable
    wr(4'd3, 8'h90);
    rd(4'd3, 8'h80, "R10 uie cleared by SET");
    upd(8'h02, 8'h00, 8'h00);
    chk_irq(1'b1, "R10 no update irq");
    rd(4'd4, 8'h10, "R10 flag without summary");

    // R6: exact alarm match
    wr(4'd3, 8'h20);
    wr(4'd0, 8'h30); wr(4'd1, 8'h15); wr(4'd2, 8'h08);
    upd(8'h30, 8'h15, 8'h08);
    chk_irq(1'b0, "R6 alarm irq");
    rd(4'd4, 8'hB0, "R6 alarm match");
    upd(8'h31, 8'h15, 8'h08);
    rd(4'd4, 8'h10, "R6 alarm mismatch");

    // R7: wildcard alarm bytes
    wr(4'd1, 8'hFF); wr(4'd2, 8'hC0);
    upd(8'h30, 8'h42, 8'h17);
    rd(4'd4, 8'hB0, "R7 wildcard match");

    // R9: event in the same cycle as the clearing read
    wr(4'd3, 8'h00);
    @(negedge clk);
    rd_en = 1'b1; addr = 4'd4; periodic_tick = 1'b1;
    exp_q.push_back(8'h00); tag_q.push_back("R9 read before event");
    @(negedge clk);
    rd_en = 1'b0; periodic_tick = 1'b0;
    rd(4'd4, 8'h40, "R9 event kept");

    // R11: validity word, read-only registers
    rd(4'd5, 8'h80, "R11 valid word");
    wr(4'd5, 8'h00);
    rd(4'd5, 8'h80, "R11 valid after write");
    wr(4'd4, 8'hFF);
    rd(4'd4, 8'h00, "R11 status write ignored");
    chk_irq(1'b1, "R11 irq after status write");

    repeat (2) @(negedge clk);
    done = 1'b1;
    report();
  end
endmodule